// File: doc/BRIEF.md
# Flash bus front end

This block is the device-side front end of a parallel NOR-style flash. It watches the active-low pins for reset, chip enable, output enable, write enable and address valid, together with the bus clock. From these it decides which of six bus operations is under way. It also keeps the internal address latch. In asynchronous mode the latch lets the address flow through; in synchronous mode it captures the address once per access.

It steers the read word from the array onto the data bus and drives the WAIT indicator. When a write ends, it hands a one-cycle strobe, carrying the write address and the write data, to the command interpreter that sits behind it.

All pins are sampled on the rising edge of the bus clock. The reset pin also acts as the asynchronous reset of every register. The tri-state bus is split into separate input, output and output-enable signals, so the pad ring above the block can build the pins.

Top module: `flash_bus_frontend`

## Requirements
- R1: While the reset pin is low, the bus operation code is 0 (reset), regardless of the other pins. Neither the data bus nor WAIT is driven, and no command strobe is issued.
- R2: With reset high and chip enable high, the operation code is 1 (standby), whatever the other pins are doing. Neither the data bus nor WAIT is driven.
- R3: With chip enable low, output enable low and write enable high, a read is decoded. The code is 3 for an asynchronous read (mode input 0) and 4 for a synchronous read (mode input 1). The data bus is driven with the array word at the presented address.
- R4: With chip enable low, address valid low, output enable high and write enable low, a write is decoded as code 5. The data bus is an input, and WAIT is not driven.
- R5: Every other combination with chip enable low decodes as code 2 (output disable), with neither the data bus nor WAIT driven. This covers output enable and write enable both high, and the illegal combinations.
- R6: In asynchronous mode the presented address equals the address input while address valid is low. After address valid rises, it holds the value sampled at the last clock edge where address valid was low.
- R7: In synchronous mode, with chip enable low and write enable high, the first clock edge that sees address valid low captures the address. Later changes on the address input do not alter the presented address until address valid has gone high again.
- R8: The block number output equals the presented address with its lowest OFFSET_W bits dropped. With the defaults, address 0x0FFF is in block 0, 0x1000 in block 1 and 0xFFFF in block 15.
- R9: During an asynchronous read, WAIT is driven at its deasserted level, 1. During a synchronous read, WAIT is driven. It reads 0 (asserted) from the capture edge for LATENCY clock edges, then 1.
- R10: When write enable is seen high at the clock edge after one that decoded a write, the command strobe is high for exactly one cycle. It carries the address and data-bus value sampled during the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Reset pin, active low; also asynchronous register reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| advN | input | 1 | Address valid, active low |
| syncMode | input | 1 | 1 selects synchronous reads, 0 asynchronous |
| addrIn | input | ADDR_W | Address pins |
| dqIn | input | DATA_W | Data bus as seen from the pins |
| rdData | input | DATA_W | Array word at addrOut |
| busOp | output | 3 | Decoded bus operation code |
| addrOut | output | ADDR_W | Presented (latched or flow-through) address |
| blockOut | output | ADDR_W-OFFSET_W | Block number of the presented address |
| dqOut | output | DATA_W | Data bus output value |
| dqOe | output | 1 | Data bus output enable |
| waitN | output | 1 | WAIT level, active low |
| waitOe | output | 1 | WAIT output enable |
| cmdStb | output | 1 | One-cycle write strobe toward the command interface |
| cmdAddr | output | ADDR_W | Address carried by the strobe |
| cmdData | output | DATA_W | Data carried by the strobe |

## Verification
The hardest case to reach is a synchronous access where the address input keeps moving while address valid stays low. Only the first sampling edge may take effect, and the WAIT countdown has to run from that same edge. A directed sequence reaches it by capturing one address and then presenting a different one while address valid is still low. It then opens output enable and checks WAIT edge by edge across the latency window. Random pin patterns, with mode switches and brief resets mixed in, then cover the decode table, including the illegal write-enable and output-enable combinations.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  typedef enum logic [2:0] {
    OP_RESET    = 3'd0,
    OP_STANDBY  = 3'd1,
    OP_OUTDIS   = 3'd2,
    OP_RD_ASYNC = 3'd3,
    OP_RD_SYNC  = 3'd4,
    OP_WRITE    = 3'd5
  } busOpE;

  typedef struct packed {
    logic addrPass;   // address flows straight through this cycle
    logic addrLoad;   // address register loads at the next edge
    logic wrCapture;  // write address and data are sampled
    logic cmdFire;    // write enable rise seen: issue command strobe
  } ctlStrobeS;
endpackage

// File: rtl/fbi_ctrl.sv
module fbi_ctrl
  import fbi_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      weN,
  input  logic      advN,
  input  logic      syncMode,
  output ctlStrobeS ctl,
  output busOpE     busOp,
  output logic      dqOe,
  output logic      waitOe,
  output logic      waitN
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic             heldQ;
  logic             prevWriteQ;
  logic [CNT_W-1:0] cntQ;
  logic             isWrite;
  logic             isRead;
  logic             syncArmed;
  logic             syncCap;

  always_comb begin
    if (!rstN)                     busOp = OP_RESET;
    else if (ceN)                  busOp = OP_STANDBY;
    else if (!oeN && weN)          busOp = syncMode ? OP_RD_SYNC : OP_RD_ASYNC;
    else if (oeN && !weN && !advN) busOp = OP_WRITE;
    else                           busOp = OP_OUTDIS;
  end

  assign isWrite   = (busOp == OP_WRITE);
  assign isRead    = (busOp == OP_RD_ASYNC) || (busOp == OP_RD_SYNC);
  assign syncArmed = rstN && syncMode && !ceN && weN;
  assign syncCap   = syncArmed && !advN && !heldQ;

  always_comb begin
    ctl.addrPass  = rstN && !advN && (!syncMode || isWrite);
    ctl.addrLoad  = ctl.addrPass || syncCap;
    ctl.wrCapture = isWrite;
    ctl.cmdFire   = rstN && prevWriteQ && weN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ      <= 1'b0;
      prevWriteQ <= 1'b0;
      cntQ       <= '0;
    end else begin
      prevWriteQ <= isWrite;
      if (advN || ceN || !syncMode) heldQ <= 1'b0;
      else if (syncCap)             heldQ <= 1'b1;
      if (!syncMode || ceN)  cntQ <= '0;
      else if (syncCap)      cntQ <= CNT_W'(LATENCY);
      else if (cntQ != '0)   cntQ <= cntQ - 1'b1;
    end
  end

  assign dqOe   = isRead;
  assign waitOe = isRead;
  assign waitN  = (busOp == OP_RD_ASYNC) ? 1'b1 : (cntQ == '0);

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || (oeN && weN)) |-> (!dqOe && !waitOe)); // R2
  AST_WAIT_ASYNC: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && !ceN && !oeN && weN) |-> (waitOe && waitN)); // R9
endmodule

// File: rtl/fbi_dpath.sv
module fbi_dpath
  import fbi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int OFFSET_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobeS              ctl,
  input  logic                   dqOe,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic [DATA_W-1:0]      dqIn,
  input  logic [DATA_W-1:0]      rdData,
  output logic [ADDR_W-1:0]      addrOut,
  output logic [ADDR_W-OFFSET_W-1:0] blockOut,
  output logic [DATA_W-1:0]      dqOut,
  output logic                   cmdStb,
  output logic [ADDR_W-1:0]      cmdAddr,
  output logic [DATA_W-1:0]      cmdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;

  assign addrOut = ctl.addrPass ? addrIn : addrQ;

  generate
    if (OFFSET_W > 0) begin : gBlk
      assign blockOut = addrOut[ADDR_W-1:OFFSET_W];
    end else begin : gNoOff
      assign blockOut = addrOut;
    end
  endgenerate

  assign dqOut = dqOe ? rdData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
      cmdStb  <= 1'b0;
      cmdAddr <= '0;
      cmdData <= '0;
    end else begin
      if (ctl.addrLoad) addrQ <= addrIn;
      if (ctl.wrCapture) begin
        wrAddrQ <= addrOut;
        wrDataQ <= dqIn;
      end
      cmdStb <= ctl.cmdFire;
      if (ctl.cmdFire) begin
        cmdAddr <= wrAddrQ;
        cmdData <= wrDataQ;
      end
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb |=> !cmdStb); // R10
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import fbi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int OFFSET_W = 12,
  parameter int LATENCY  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ceN,
  input  logic                       oeN,
  input  logic                       weN,
  input  logic                       advN,
  input  logic                       syncMode,
  input  logic [ADDR_W-1:0]          addrIn,
  input  logic [DATA_W-1:0]          dqIn,
  input  logic [DATA_W-1:0]          rdData,
  output logic [2:0]                 busOp,
  output logic [ADDR_W-1:0]          addrOut,
  output logic [ADDR_W-OFFSET_W-1:0] blockOut,
  output logic [DATA_W-1:0]          dqOut,
  output logic                       dqOe,
  output logic                       waitN,
  output logic                       waitOe,
  output logic                       cmdStb,
  output logic [ADDR_W-1:0]          cmdAddr,
  output logic [DATA_W-1:0]          cmdData
);
  ctlStrobeS ctl;
  busOpE     opE;
  logic      armedNow;

  fbi_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .advN(advN), .syncMode(syncMode), .ctl(ctl), .busOp(opE),
    .dqOe(dqOe), .waitOe(waitOe), .waitN(waitN)
  );

  fbi_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET_W(OFFSET_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dqOe(dqOe), .addrIn(addrIn),
    .dqIn(dqIn), .rdData(rdData), .addrOut(addrOut), .blockOut(blockOut),
    .dqOut(dqOut), .cmdStb(cmdStb), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  assign busOp    = opE;
  assign armedNow = rstN && syncMode && !ceN && weN && !advN;

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (armedNow && $past(armedNow) && $past(armedNow, 2)) |-> $stable(addrOut)); // R7
  AST_STB_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb |-> ($past(busOp, 2) == 3'd5)); // R10
endmodule

// File: tb/tb_flash_bus_frontend.sv
module tb_flash_bus_frontend;
  localparam int CLK_P    = 10;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 16;
  localparam int OFFSET_W = 12;
  localparam int LATENCY  = 3;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN, advN, syncMode;
  logic [ADDR_W-1:0] addrIn;
  logic [DATA_W-1:0] dqIn, rdData;
  logic [2:0] busOp;
  logic [ADDR_W-1:0] addrOut, cmdAddr;
  logic [ADDR_W-OFFSET_W-1:0] blockOut;
  logic [DATA_W-1:0] dqOut, cmdData;
  logic dqOe, waitN, waitOe, cmdStb;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h3C};
  endfunction

  assign rdData = memWord(addrOut);

  flash_bus_frontend #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET_W(OFFSET_W),
                       .LATENCY(LATENCY)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
    .syncMode(syncMode), .addrIn(addrIn), .dqIn(dqIn), .rdData(rdData),
    .busOp(busOp), .addrOut(addrOut), .blockOut(blockOut), .dqOut(dqOut),
    .dqOe(dqOe), .waitN(waitN), .waitOe(waitOe), .cmdStb(cmdStb),
    .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  function automatic logic [2:0] expOp(input logic r, ce, oe, we, adv, sm);
    if (!r) return 3'd0;
    if (ce) return 3'd1;
    if (!oe && we) return sm ? 3'd4 : 3'd3;
    if (oe && !we && !adv) return 3'd5;
    return 3'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'h1F2E));
    rstN = 1'b0; ceN = 1'b0; oeN = 1'b0; weN = 1'b1; advN = 1'b0;
    syncMode = 1'b0; addrIn = 16'h1234; dqIn = '0;
    settle();
    // R1: reset overrides an otherwise valid read
    check("R1 op", busOp, 3'd0);
    check("R1 dqOe", dqOe, 1'b0);
    check("R1 waitOe", waitOe, 1'b0);
    check("R1 cmdStb", cmdStb, 1'b0);
    nextCycle();
    rstN = 1'b1; ceN = 1'b1;
    settle();
    check("R2 op", busOp, 3'd1);
    check("R2 dqOe", dqOe, 1'b0);

    // R5 illegal combination: output and write enable both low
    nextCycle();
    ceN = 1'b0; oeN = 1'b0; weN = 1'b0; advN = 1'b1;
    settle();
    check("R5 op", busOp, 3'd2);
    check("R5 waitOe", waitOe, 1'b0);

    // R6 asynchronous flow-through then hold
    nextCycle();
    weN = 1'b1; advN = 1'b0; addrIn = 16'h0FFF;
    settle();
    check("R6 pass", addrOut, 16'h0FFF);
    check("R8 block0", blockOut, 4'd0);
    check("R3 op", busOp, 3'd3);
    check("R3 data", dqOut, memWord(16'h0FFF));
    check("R9 async wait", {waitOe, waitN}, 2'b11);
    nextCycle();
    addrIn = 16'h1000;
    settle();
    check("R6 pass2", addrOut, 16'h1000);
    check("R8 block1", blockOut, 4'd1);
    nextCycle();
    advN = 1'b1; addrIn = 16'hFFFF;
    settle();
    check("R6 hold", addrOut, 16'h1000);
    check("R3 hold data", dqOut, memWord(16'h1000));
    nextCycle();
    advN = 1'b0;
    settle();
    check("R8 block15", blockOut, 4'd15);

    // R7 and R9 synchronous capture and latency
    nextCycle();
    ceN = 1'b1; advN = 1'b1;
    nextCycle();
    syncMode = 1'b1; ceN = 1'b0; oeN = 1'b1; weN = 1'b1; advN = 1'b0;
    addrIn = 16'hA5A5;
    nextCycle();                 // capture edge
    addrIn = 16'h3C3C;
    settle();
    check("R7 capture", addrOut, 16'hA5A5);
    check("R5 op", busOp, 3'd2);
    nextCycle();                 // second edge after capture
    check("R7 ignore", addrOut, 16'hA5A5);
    advN = 1'b1; oeN = 1'b0; addrIn = 16'h7777;
    settle();
    check("R3 sync op", busOp, 3'd4);
    check("R7 held", addrOut, 16'hA5A5);
    check("R3 sync data", dqOut, memWord(16'hA5A5));
    check("R9 wait n2", {waitOe, waitN}, {1'b1, (2 >= LATENCY + 1)});
    for (int n = 3; n <= 7; n++) begin
      nextCycle();
      settle();
      check("R9 wait", {waitOe, waitN}, {1'b1, (n >= LATENCY + 1)});
    end

    // R4 and R10 write strobe
    nextCycle();
    syncMode = 1'b0; oeN = 1'b1; weN = 1'b0; advN = 1'b0;
    addrIn = 16'h4321; dqIn = 16'hBEEF;
    settle();
    check("R4 op", busOp, 3'd5);
    check("R4 hiz", {dqOe, waitOe}, 2'b00);
    nextCycle();                 // edge samples the write
    weN = 1'b1; advN = 1'b1; dqIn = 16'h0000; addrIn = 16'h9999;
    settle();
    check("R10 not yet", cmdStb, 1'b0);
    nextCycle();                 // edge sees write enable high
    settle();
    check("R10 stb", cmdStb, 1'b1);
    check("R10 addr", cmdAddr, 16'h4321);
    check("R10 data", cmdData, 16'hBEEF);
    nextCycle();
    settle();
    check("R10 once", cmdStb, 1'b0);

    // random pin patterns against the decode table
    for (int i = 0; i < 400; i++) begin
      nextCycle();
      rstN = ($urandom % 16) != 0;
      ceN = $urandom % 2; oeN = $urandom % 2; weN = $urandom % 2;
      advN = $urandom % 2; syncMode = $urandom % 2;
      addrIn = ADDR_W'($urandom); dqIn = DATA_W'($urandom);
      settle();
      check("R1-decode R2 R3 R4 R5 op", busOp, expOp(rstN, ceN, oeN, weN, advN, syncMode));
      check("R3 R5 dqOe", dqOe, (expOp(rstN, ceN, oeN, weN, advN, syncMode) inside {3'd3, 3'd4}));
      if (dqOe) check("R3 rand data", dqOut, memWord(addrOut));
      if (rstN && !syncMode && !advN) check("R6 rand pass", addrOut, addrIn);
      check("R8 rand block", blockOut, addrOut[ADDR_W-1:OFFSET_W]);
    end
    nextCycle();
    finish();
  end
endmodule